// File: doc/BRIEF.md
# Endpoint Stall Handshake Controller

This block sits between the bus-side token decoder and the packet engine of a device endpoint. For each decoded token it decides which handshake the endpoint returns. When firmware raises its stall-request bit, data-phase tokens are answered with STALL instead of the engine's usual ACK or NAK. When no stall is requested, the engine's choice passes through unchanged.

Each STALL that the packet engine actually takes is recorded in a sticky stall-sent flag. That flag drives the endpoint interrupt until firmware clears it. A stall serves one of two purposes. A functional stall halts a non-control endpoint until firmware withdraws the request. A protocol stall on a control endpoint aborts the current request, and it ends by itself when the next SETUP arrives. A SETUP on a control endpoint is always accepted.

Tokens enter through a valid/ready port. The handshake decision leaves through a one-entry valid/ready output register. A token is taken only when `tok_valid_i` and `tok_ready_o` are both high. `tok_ready_o` is high whenever the output register is empty, or is being drained in the same cycle. A decision that has been presented stays unchanged until `hs_ready_i` accepts it.

Top module: `stall_hs_ctrl`

## Requirements
- R1: After reset, `hs_valid_o`, `stall_sent_o` and `irq_o` are 0 and `tok_ready_o` is 1.
- R2: A token is accepted on a clock edge where `tok_valid_i` and `tok_ready_o` are both 1. Its handshake appears on `hs_code_o` with `hs_valid_o`=1 after that edge. It stays stable until a clock edge where `hs_ready_i`=1. `tok_ready_o` is 0 while a result is held and `hs_ready_i` is 0.
- R3: Handshake codes are ACK=2'b00, NAK=2'b01 and STALL=2'b10. Token kinds on `tok_kind_i` are OUT=2'b00, IN=2'b01 and SETUP=2'b10, and 2'b11 is handled like a data token. When no stall is active, the code returned for an IN or OUT token equals `eng_hs_i`.
- R4: A stall becomes active when `force_stall_i` goes from 0 to 1. While it is active, IN and OUT tokens are answered with STALL.
- R5: On a control endpoint (`ep_ctrl_i`=1), a SETUP token is always answered with ACK, whatever `force_stall_i` and `eng_hs_i` are.
- R6: On a control endpoint, an accepted SETUP ends an active stall. Later IN and OUT tokens get the engine's choice while `force_stall_i` stays 1. A new stall needs `force_stall_i` to drop to 0 and rise again.
- R7: On a non-control endpoint, a SETUP does not end the stall. While the stall is active, that SETUP is itself answered with STALL.
- R8: `stall_sent_o` is set on the clock edge where a STALL code is transferred (`hs_valid_o`, `hs_ready_i` and code STALL). A STALL that is held but not yet taken does not set it.
- R9: `stall_sent_o` stays set until a clock edge with `stall_sent_clr_i`=1. A clear strobe on the same edge as a STALL transfer leaves the flag set.
- R10: `irq_o` is high exactly when `stall_sent_o` is high.
- R11: A SETUP that arrives after a STALL has been sent does not clear `stall_sent_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_stall_i | input | 1 | Firmware stall-request bit (level) |
| stall_sent_clr_i | input | 1 | Firmware clear strobe for the stall-sent flag |
| ep_ctrl_i | input | 1 | 1 when the endpoint is a control endpoint |
| tok_valid_i | input | 1 | Decoded token present |
| tok_ready_o | output | 1 | Block can take a token this cycle |
| tok_kind_i | input | 2 | Token kind (OUT, IN, SETUP) |
| eng_hs_i | input | 2 | Packet engine's normal handshake choice for this token |
| hs_valid_o | output | 1 | Handshake decision present |
| hs_ready_i | input | 1 | Packet engine takes the decision |
| hs_code_o | output | 2 | Selected handshake (ACK, NAK, STALL) |
| stall_sent_o | output | 1 | Sticky flag: a STALL reached the host |
| irq_o | output | 1 | Endpoint interrupt |

## Verification
The hardest case to reach is the edge where a held STALL is finally taken and firmware's clear strobe arrives on that same edge. This needs the flag already set, a stalled token parked behind a low `hs_ready_i`, and then ready and clear raised together. The bench builds that state step by step, and it also confirms that the parked STALL does not set the flag early. Protocol-stall disarming needs a forced stall, then a SETUP on a control endpoint, then data tokens with the request still held. The vector table walks that order before it drops and raises the request again to re-arm.

// File: rtl/stall_hs_pkg.sv
package stall_hs_pkg;
  localparam int HS_W  = 2;
  localparam int TOK_W = 2;

  typedef enum logic [HS_W-1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_RSVD  = 2'd3
  } hs_e;

  typedef enum logic [TOK_W-1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_OTHER = 2'd3
  } tok_e;
endpackage

// File: rtl/stall_hs_decide.sv
// Chooses the handshake for a token and tracks the stall-armed state.
module stall_hs_decide
  import stall_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_i,
  input  logic             ctrl_i,
  input  logic             take_i,
  input  logic [TOK_W-1:0] kind_i,
  input  logic [HS_W-1:0]  eng_i,
  output logic [HS_W-1:0]  code_o
);
  logic force_q;
  logic armed_q;
  logic stall_now;
  logic is_setup;
  logic ctrl_setup_take;

  assign is_setup        = (kind_i == TK_SETUP);
  // A rising request counts as armed in the cycle it rises.
  assign stall_now       = force_i && (armed_q || !force_q);
  assign ctrl_setup_take = take_i && ctrl_i && is_setup;

  always_comb begin
    if (ctrl_i && is_setup)
      code_o = HS_ACK;
    else if (stall_now)
      code_o = HS_STALL;
    else
      code_o = eng_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      force_q <= force_i;
      if (!force_i)
        armed_q <= 1'b0;
      else if (ctrl_setup_take)
        armed_q <= 1'b0;
      else if (!force_q)
        armed_q <= 1'b1;
    end
  end

  // R6: a SETUP taken on a control endpoint leaves the stall disarmed
  a_r6_setup_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_setup_take |=> !armed_q);

  // R4: the request held across cycles keeps the stall armed unless a control SETUP came
  a_r4_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && force_i && !ctrl_setup_take) |=> armed_q);
endmodule

// File: rtl/stall_hs_slot.sv
// One-entry valid/ready holding register for the handshake decision.
module stall_hs_slot
  import stall_hs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [HS_W-1:0] in_code_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [HS_W-1:0] out_code_o,
  output logic            take_o,
  output logic            stall_xfer_o
);
  logic            valid_q;
  logic [HS_W-1:0] code_q;

  assign in_ready_o   = !valid_q || out_ready_i;
  assign take_o       = in_valid_i && in_ready_o;
  assign out_valid_o  = valid_q;
  assign out_code_o   = code_q;
  assign stall_xfer_o = valid_q && out_ready_i && (code_q == HS_STALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= HS_ACK;
    end else begin
      if (take_o) begin
        valid_q <= 1'b1;
        code_q  <= in_code_i;
      end else if (out_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  // R2: a held decision stays put until taken
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready_i) |=> (valid_q && $stable(code_q)));
endmodule

// File: rtl/stall_hs_flag.sv
// Sticky stall-sent flag and the interrupt it drives.
module stall_hs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (set_i)
      flag_q <= 1'b1;
    else if (clr_i)
      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q;

  // R9: only a clear strobe drops the flag
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R8: the flag rises only after a stall transfer
  a_r8_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !set_i) |=> !flag_q);
endmodule

// File: rtl/stall_hs_ctrl.sv
module stall_hs_ctrl
  import stall_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_stall_i,
  input  logic             stall_sent_clr_i,
  input  logic             ep_ctrl_i,
  input  logic             tok_valid_i,
  output logic             tok_ready_o,
  input  logic [TOK_W-1:0] tok_kind_i,
  input  logic [HS_W-1:0]  eng_hs_i,
  output logic             hs_valid_o,
  input  logic             hs_ready_i,
  output logic [HS_W-1:0]  hs_code_o,
  output logic             stall_sent_o,
  output logic             irq_o
);
  logic            take;
  logic            stall_xfer;
  logic [HS_W-1:0] pick;

  stall_hs_decide u_decide (
    .clk     (clk),
    .rst_n   (rst_n),
    .force_i (force_stall_i),
    .ctrl_i  (ep_ctrl_i),
    .take_i  (take),
    .kind_i  (tok_kind_i),
    .eng_i   (eng_hs_i),
    .code_o  (pick)
  );

  stall_hs_slot u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (tok_valid_i),
    .in_ready_o   (tok_ready_o),
    .in_code_i    (pick),
    .out_valid_o  (hs_valid_o),
    .out_ready_i  (hs_ready_i),
    .out_code_o   (hs_code_o),
    .take_o       (take),
    .stall_xfer_o (stall_xfer)
  );

  stall_hs_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (stall_xfer),
    .clr_i  (stall_sent_clr_i),
    .flag_o (stall_sent_o),
    .irq_o  (irq_o)
  );

  // R5: control SETUP always gets ACK
  a_r5_setup_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid_i && tok_ready_o && ep_ctrl_i && tok_kind_i == TK_SETUP)
      |=> (hs_valid_o && hs_code_o == HS_ACK));

  // R3: with no request the engine's choice passes through
  a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid_i && tok_ready_o && !force_stall_i && tok_kind_i != TK_SETUP)
      |=> (hs_code_o == $past(eng_hs_i)));

  // R11: a SETUP does not clear the stall-sent flag
  a_r11_setup_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_sent_o && !stall_sent_clr_i && tok_valid_i && tok_kind_i == TK_SETUP)
      |=> stall_sent_o);
endmodule

// File: tb/stall_hs_ctrl_test.sv
module stall_hs_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       force_stall = 1'b0;
  logic       clr = 1'b0;
  logic       ctrl = 1'b0;
  logic       tok_valid = 1'b0;
  logic       tok_ready;
  logic [1:0] tok_kind = 2'd0;
  logic [1:0] eng_hs = 2'd0;
  logic       hs_valid;
  logic       hs_ready = 1'b1;
  logic [1:0] hs_code;
  logic       stall_sent;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stall_hs_ctrl uut (
    .clk(clk), .rst_n(rst_n), .force_stall_i(force_stall),
    .stall_sent_clr_i(clr), .ep_ctrl_i(ctrl),
    .tok_valid_i(tok_valid), .tok_ready_o(tok_ready),
    .tok_kind_i(tok_kind), .eng_hs_i(eng_hs),
    .hs_valid_o(hs_valid), .hs_ready_i(hs_ready), .hs_code_o(hs_code),
    .stall_sent_o(stall_sent), .irq_o(irq)
  );

  // {force, ctrl, kind[1:0], eng[1:0], exp_code[1:0], exp_sent}
  localparam logic [8:0] VEC [13] = '{
    {1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0}, // R3 OUT pass ACK
    {1'b0, 1'b0, 2'd1, 2'd1, 2'd1, 1'b0}, // R3 IN pass NAK
    {1'b1, 1'b0, 2'd1, 2'd0, 2'd2, 1'b1}, // R4 rising request stalls IN
    {1'b1, 1'b0, 2'd2, 2'd0, 2'd2, 1'b1}, // R7 non-control SETUP stalled
    {1'b1, 1'b0, 2'd0, 2'd1, 2'd2, 1'b1}, // R7 stall persists after SETUP
    {1'b0, 1'b1, 2'd1, 2'd1, 2'd1, 1'b1}, // R9 flag held, request dropped
    {1'b1, 1'b1, 2'd0, 2'd0, 2'd2, 1'b1}, // R4 control protocol stall
    {1'b1, 1'b1, 2'd2, 2'd1, 2'd0, 1'b1}, // R5 R11 SETUP acked, flag kept
    {1'b1, 1'b1, 2'd1, 2'd1, 2'd1, 1'b1}, // R6 disarmed, NAK passes
    {1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 1'b1}, // R6 disarmed, ACK passes
    {1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 1'b1}, // R6 request dropped
    {1'b1, 1'b1, 2'd1, 2'd1, 2'd2, 1'b1}, // R6 re-armed by new rise
    {1'b0, 1'b1, 2'd2, 2'd1, 2'd0, 1'b1}  // R5 SETUP without request
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_token(input logic [1:0] kind, input logic [1:0] eng);
    @(negedge clk);
    tok_kind  = kind;
    eng_hs    = eng;
    tok_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hs_valid", int'(hs_valid), 0);
    check("R1 stall_sent", int'(stall_sent), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 tok_ready", int'(tok_ready), 1);

    // Vector table walk: ready held high, one token per entry
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      force_stall = VEC[i][8];
      ctrl        = VEC[i][7];
      send_token(VEC[i][6:5], VEC[i][4:3]);
      check($sformatf("R2 valid v%0d", i), int'(hs_valid), 1);
      check($sformatf("R3 R4 R5 R6 R7 code v%0d", i), int'(hs_code), int'(VEC[i][2:1]));
      @(negedge clk);
      check($sformatf("R8 R9 R11 sent v%0d", i), int'(stall_sent), int'(VEC[i][0]));
      check($sformatf("R10 irq v%0d", i), int'(irq), int'(VEC[i][0]));
    end

    // R9: clear strobe drops flag and interrupt
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R9 cleared", int'(stall_sent), 0);
    check("R10 irq cleared", int'(irq), 0);

    // R2 R8: back-pressure holds a STALL and it does not set the flag yet
    force_stall = 1'b0;
    ctrl = 1'b0;
    @(negedge clk);
    force_stall = 1'b1;
    hs_ready = 1'b0;
    send_token(2'd1, 2'd0);
    check("R4 held code", int'(hs_code), 2);
    repeat (2) @(negedge clk);
    check("R2 held valid", int'(hs_valid), 1);
    check("R2 held code", int'(hs_code), 2);
    check("R2 tok_ready low", int'(tok_ready), 0);
    check("R8 no set before transfer", int'(stall_sent), 0);
    hs_ready = 1'b1;
    @(negedge clk);
    check("R8 set on transfer", int'(stall_sent), 1);
    check("R2 drained", int'(hs_valid), 0);

    // R9: clear in the same cycle as a STALL transfer keeps the flag
    hs_ready = 1'b0;
    send_token(2'd0, 2'd1);
    check("R4 second held code", int'(hs_code), 2);
    hs_ready = 1'b1;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    hs_ready = 1'b1;
    check("R9 set wins over clear", int'(stall_sent), 1);
    @(negedge clk);
    check("R8 no extra set", int'(stall_sent), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R9 later clear", int'(stall_sent), 0);
    check("R10 irq low", int'(irq), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule